// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter with Preset

This block is a binary up-counter built from identical digit stages. Each stage is `DIGIT_W` bits wide, four by default. All stages share one clock, and every register changes only on the rising edge. At that edge a zero request and a preset request both take precedence over counting, and zero wins when both are asserted. When neither request is present, the count advances only if two enable inputs are both high. One enable only permits counting. The other also feeds forward into the stage's carry output, and the next stage up uses that carry as its own pass-through enable.

The top level chains `STAGES` digits into one wider counter, two by default, which gives eight bits. It exposes the carry of the highest digit, and that carry can in turn drive further chained instances with no extra gating. The count has no defined value at power-up, so the user applies a zero request before relying on it. Bit 0 of the preset word loads into bit 0 of the count, which is the least significant bit.

Top module: `bincnt_chain`

## Requirements
- R1: When `zero_n` is 0 at a rising edge, every bit of `count` is 0 after that edge, whatever `preset_n`, `cnt_en`, `chain_en` and `preset_val` are.
- R2: When `zero_n` is 1 and `preset_n` is 0 at a rising edge, `count` equals `preset_val` after that edge, with bit i of `preset_val` landing in bit i of `count`, whatever the two enables are.
- R3: When `zero_n` and `preset_n` are both 1 and `cnt_en` and `chain_en` are both 1 at a rising edge, `count` increases by exactly one at that edge.
- R4: When `zero_n` and `preset_n` are both 1 and either enable is 0 at a rising edge, `count` keeps its value. Between rising edges `count` never changes, whatever the control inputs do.
- R5: A count at its all-ones value (255 with the default parameters) goes to 0 on the next counting edge.
- R6: Each digit's carry is combinational and is 1 exactly while that digit is all ones and its pass-through enable is 1. A digit above the lowest takes the carry of the digit below it as its pass-through enable.
- R7: `carry_out` is 1 only while `count` is all ones and `chain_en` is 1. It responds to `chain_en` in the same cycle, without waiting for a clock edge.
- R8: This sequence must give the following low-digit values after successive edges: a zero request, then a preset of 12, then enabled counting. The values are 0, 12, 13, 14, 15, 0, 1, 2. Dropping `cnt_en` after that holds the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| zero_n | input | 1 | Active-low synchronous zero request; highest priority |
| preset_n | input | 1 | Active-low synchronous preset request |
| cnt_en | input | 1 | Count permit shared by all digits |
| chain_en | input | 1 | Count permit that also gates the carry of the lowest digit |
| preset_val | input | DIGIT_W*STAGES | Value loaded by a preset request; bit 0 is the least significant bit |
| count | output | DIGIT_W*STAGES | Current count; bit 0 is the least significant bit |
| carry_out | output | 1 | Carry of the highest digit, for chaining further instances |

## Verification
Zero, preset, count and hold results appear one edge after the inputs that cause them. The bench drives the inputs on the falling edge and compares `count` one time unit after the following rising edge, against a model stepped once per edge. The carry has no register stage. The bench therefore checks it shortly after the inputs change and before the next rising edge, using the count held since the previous edge and the newly driven `chain_en`. Random mixes of the four requests run alongside directed cases: the 0, 12, 13 … 2 sequence, the wrap through 255, presets with both enables low, and a zero request that arrives together with a preset request.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_COUNT  = 2'd1,
      OP_PRESET = 2'd2,
      OP_ZERO   = 2'd3
   } op_e;

   // Priority: zero request, then preset request, then enabled counting.
   function automatic op_e pick_op(input logic zero_n, input logic preset_n,
                                   input logic cnt_en, input logic pass_en);
      if (!zero_n)                 return OP_ZERO;
      else if (!preset_n)          return OP_PRESET;
      else if (cnt_en && pass_en)  return OP_COUNT;
      else                         return OP_HOLD;
   endfunction

endpackage

// File: rtl/bincnt_carry.sv
module bincnt_carry #(
   parameter int W = 4
) (
   input  logic [W-1:0] value,
   input  logic         pass_en,
   output logic         carry
);
   if (W < 1) begin : g_bad_width
      $error("bincnt_carry: W must be at least 1");
   end

   // Terminal-count detect gated by the feed-forward enable (R6).
   assign carry = pass_en & (&value);
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
   import bincnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         zero_n,
   input  logic         preset_n,
   input  logic         cnt_en,
   input  logic         pass_en,
   input  logic [W-1:0] preset_val,
   output logic [W-1:0] count,
   output logic         carry
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   if (W < 1) begin : g_bad_width
      $error("bincnt_stage: W must be at least 1");
   end

   op_e          op;
   logic [W-1:0] nxt;

   assign op = pick_op(zero_n, preset_n, cnt_en, pass_en);

   always_comb begin
      unique case (op)
         OP_ZERO:   nxt = '0;
         OP_PRESET: nxt = preset_val;
         OP_COUNT:  nxt = count + ONE;
         default:   nxt = count;
      endcase
   end

   always_ff @(posedge clk) count <= nxt;

   bincnt_carry #(.W(W)) u_carry (
      .value   (count),
      .pass_en (pass_en),
      .carry   (carry)
   );

   // Assertion qualifier: $past is meaningful only after the first edge.
   logic past_ok = 1'b0;
   always_ff @(posedge clk) past_ok <= 1'b1;

   assert_zero_wins_R1: assert property (@(posedge clk) disable iff (!past_ok)
      !zero_n |=> count == '0);

   assert_preset_loads_R2: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && !preset_n) |=> count == $past(preset_val));

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && preset_n && cnt_en && pass_en) |=> count == $past(count) + ONE);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && preset_n && !(cnt_en && pass_en)) |=> $stable(count));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && preset_n && cnt_en && pass_en && count == ALL_ONES) |=> count == '0);

   always_comb begin
      assert_carry_gate_R6: assert (!carry || (pass_en && count == ALL_ONES));
   end
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain #(
   parameter int DIGIT_W   = 4,
   parameter int STAGES    = 2,
   parameter bit LOOKAHEAD = 1'b0
) (
   input  logic                        clk,
   input  logic                        zero_n,
   input  logic                        preset_n,
   input  logic                        cnt_en,
   input  logic                        chain_en,
   input  logic [DIGIT_W*STAGES-1:0]   preset_val,
   output logic [DIGIT_W*STAGES-1:0]   count,
   output logic                        carry_out
);
   localparam int TOTAL_W = DIGIT_W * STAGES;
   localparam logic [TOTAL_W-1:0] FULL = {TOTAL_W{1'b1}};

   if (DIGIT_W < 1) begin : g_bad_digit
      $error("bincnt_chain: DIGIT_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("bincnt_chain: STAGES must be at least 1");
   end

   logic [STAGES-1:0] carry_vec;
   logic [STAGES-1:0] pass_vec;

   logic past_ok = 1'b0;
   always_ff @(posedge clk) past_ok <= 1'b1;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign pass_vec[k] = chain_en;
      end else if (LOOKAHEAD) begin : g_look
         // Enable formed directly from all lower digits: one AND level.
         assign pass_vec[k] = chain_en & (&count[k*DIGIT_W-1:0]);
         always_comb begin
            assert_look_matches_R6: assert (pass_vec[k] == carry_vec[k-1]);
         end
      end else begin : g_ripple
         assign pass_vec[k] = carry_vec[k-1];
      end

      bincnt_stage #(.W(DIGIT_W)) u_digit (
         .clk        (clk),
         .zero_n     (zero_n),
         .preset_n   (preset_n),
         .cnt_en     (cnt_en),
         .pass_en    (pass_vec[k]),
         .preset_val (preset_val[k*DIGIT_W +: DIGIT_W]),
         .count      (count[k*DIGIT_W +: DIGIT_W]),
         .carry      (carry_vec[k])
      );
   end

   assign carry_out = carry_vec[STAGES-1];

   always_comb begin
      assert_top_carry_R7: assert (!carry_out || (chain_en && count == FULL));
   end

   assert_wide_step_R3: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && preset_n && cnt_en && chain_en) |=> count == $past(count) + 1'b1);

   assert_wide_wrap_R5: assert property (@(posedge clk) disable iff (!past_ok)
      (zero_n && preset_n && cnt_en && chain_en && count == FULL) |=> count == '0);
endmodule

// File: tb/sim_bincnt_chain.sv
module sim_bincnt_chain;
   localparam int DW = 4;
   localparam int NS = 2;
   localparam int TW = DW * NS;

   logic          clk = 1'b0;
   logic          zero_n = 1'b1, preset_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
   logic [TW-1:0] preset_val = '0;
   logic [TW-1:0] count;
   logic          carry_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [TW-1:0] exp_q = '0;

   always #2 clk = ~clk;   // 4 ns period

   bincnt_chain #(.DIGIT_W(DW), .STAGES(NS)) u0 (
      .clk(clk), .zero_n(zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
      .chain_en(chain_en), .preset_val(preset_val), .count(count),
      .carry_out(carry_out)
   );

   // Single-digit behaviour taken from the requirements.
   function automatic logic [DW-1:0] digit_next(logic [DW-1:0] q, logic z, logic p,
                                                logic ce, logic pe, logic [DW-1:0] d);
      if (!z)            return '0;
      else if (!p)       return d;
      else if (ce && pe) return q + 1'b1;
      else               return q;
   endfunction

   function automatic logic [TW-1:0] chain_next(logic [TW-1:0] q, logic z, logic p,
                                                logic ce, logic te, logic [TW-1:0] d);
      logic [TW-1:0] r;
      logic pe;
      pe = te;
      for (int k = 0; k < NS; k++) begin
         r[k*DW +: DW] = digit_next(q[k*DW +: DW], z, p, ce, pe, d[k*DW +: DW]);
         pe = pe & (&q[k*DW +: DW]);
      end
      return r;
   endfunction

   task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   // One cycle: drive on the falling edge, check carry, then count after the edge.
   task automatic step(logic z, logic p, logic ce, logic te, logic [TW-1:0] d, string tag);
      @(negedge clk);
      zero_n = z; preset_n = p; cnt_en = ce; chain_en = te; preset_val = d;
      #1;
      check("R7 carry", {{(TW-1){1'b0}}, carry_out},
            {{(TW-1){1'b0}}, (exp_q == {TW{1'b1}}) && te});
      exp_q = chain_next(exp_q, z, p, ce, te, d);
      @(posedge clk);
      #1;
      check(tag, count, exp_q);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      // Power-up contents unknown: zero with preset and enables also active (R1).
      step(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, "R1 zero over preset");
      check("R1 reset state", count, 8'h00);

      // R8 sequence on the low digit: 0,12,13,14,15,0,1,2 then hold.
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R8 zero");
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0C, "R8 preset 12");
      check("R8 low digit 12", {4'h0, count[3:0]}, 8'd12);
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 count");
         check("R8 low digit", {4'h0, count[3:0]}, 8'((13 + i) % 16));
      end
      check("R8 upper digit after carry", {4'h0, count[7:4]}, 8'd1);
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R8 inhibit cnt_en");
      check("R8 held at 2", {4'h0, count[3:0]}, 8'd2);
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 inhibit chain_en");

      // R2 preset ignores enables and maps bit i to bit i.
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h81, "R2 preset enables low");
      check("R2 bit mapping", count, 8'h81);

      // R5/R7 wrap through all ones; carry follows chain_en between edges.
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, "R2 preset FE");
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3 count to FF");
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 hold at FF chain_en low");
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R4 hold at FF cnt_en low");
      @(negedge clk);
      chain_en = 1'b0; #1;
      check("R7 carry drops with chain_en", {7'd0, carry_out}, 8'd0);
      chain_en = 1'b1; #1;
      check("R7 carry rises with chain_en", {7'd0, carry_out}, 8'd1);
      check("R4 no change between edges", count, 8'hFF);
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 wrap to zero");
      check("R5 wrapped", count, 8'h00);

      // R6: low digit at 15 with chain_en low must not advance the upper digit.
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3F, "R2 preset 3F");
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 no carry without chain_en");
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6 carry into upper digit");
      check("R6 upper advanced", count, 8'h40);

      // Constrained random mix.
      void'($urandom(32'd1163));
      for (int i = 0; i < 3000; i++) begin
         logic z, p, ce, te;
         z  = ($urandom % 16) != 0;
         p  = ($urandom % 8) != 0;
         ce = ($urandom % 8) != 0;
         te = ($urandom % 6) != 0;
         step(z, p, ce, te, 8'($urandom), "R3 random mix");
      end
      finish_run();
   end
endmodule